// File: doc/BRIEF.md
# CCD Vertical Charge Sweep Sequencer

This block drives the fast vertical clearing burst that empties the vertical transfer register of an interline CCD before a still frame is read out. A start request from the line and field timing generator arms a sweep. The block then counts line-start pulses and pixel clocks. Inside a fixed window of lines it steps the four vertical phase outputs on a regular grid of clock positions. It stops once the programmed number of transfer stages has been issued and marks that moment with a one-cycle done pulse.

The block also controls when exposure may happen around the overflow-drain control. Once the drain control goes high, a settle timer counts a parameterised number of clocks before it grants exposure. A start request waits while exposure is still in progress. Accepting a sweep withdraws the exposure grant, and the grant only comes back after the drain control has gone low and then high again. A start request that arrives during a sweep is dropped and flagged in a sticky error bit.

Top module: `ccd_sweep_seq`

## Requirements
- R1: While reset is high and after its release, `vphase` is 4'b0011 (phases 0 and 1 high), and `sweeping`, `sweep_done`, `expose_ok` and `start_err` are all 0.
- R2: `expose_ok` is 1 in the cycle after `drain_hi` has been sampled high on SETTLE_CLKS consecutive clock edges, as long as no lock is in force. One edge with `drain_hi` low clears it on that edge.
- R3: A start request made while `expose_busy` is 1 is held pending. No phase moves and `sweeping` stays 0 until `expose_busy` is sampled 0, and the sweep is accepted on that edge.
- R4: Accepting a sweep clears `expose_ok` on the accepting edge. It stays 0 while `drain_hi` stays high, and it is granted again only after `drain_hi` goes low and then completes a new settle count.
- R5: Acceptance sets the line number to 0, and each `hd` pulse during the sweep adds 1. Phase edges occur only on lines FIRST_LINE through LAST_LINE, and `sweeping` is 1 exactly on those lines while the sweep runs.
- R6: Within a sweep line, the phase edges are scheduled at pixel counts EDGE_OFFSET + n·EDGE_SPACING for n from 0 to EDGES_PER_LINE−1. The pixel count is 0 in the cycle after `hd` is sampled. A scheduled edge shows on `vphase` one cycle later.
- R7: Each edge changes exactly one phase, in a repeating order of eight: raise 2, drop 0, raise 3, drop 1, raise 0, drop 2, raise 1, drop 3. Four edges make one transfer stage.
- R8: A sweep issues exactly STAGES stages and then stops even if the line window is still open. `sweep_done` is a one-cycle pulse on the same edge that shows the final phase change.
- R9: A phase falls only if the next phase in rotation (phase k+1 mod 4) has been high for at least MIN_OVERLAP cycles.
- R10: A start request that arrives while a sweep runs is ignored, and it sets `start_err`. `start_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle request to begin a sweep |
| hd | input | 1 | One-cycle line-start pulse |
| drain_hi | input | 1 | Overflow-drain control level (high = drain enabled) |
| expose_busy | input | 1 | High while an exposure is still running |
| vphase | output | 4 | Vertical phase drive levels |
| sweeping | output | 1 | Sweep is running and the current line lies inside the window |
| sweep_done | output | 1 | One-cycle pulse with the final stage |
| expose_ok | output | 1 | Exposure may start |
| start_err | output | 1 | Sticky flag for a start request received mid-sweep |

## Verification
The hardest situation to reach is a start request that sits pending behind a running exposure, with line pulses arriving the whole time that must not move any phase. The stimulus raises `expose_busy` before the request and keeps clocking several full lines. It then drops busy and follows every later edge back to the line on which acceptance happened. A second request is injected halfway through the sweep, so the ignore path and the sticky error can be observed while the stage count runs to its unchanged end. The settle timer is driven with hold lengths just below, at and above its limit.

// File: rtl/ccd_sweep_pkg.sv
package ccd_sweep_pkg;

    localparam int NPH = 4;

    // Rest level of the phase outputs: phases 0 and 1 high
    localparam logic [NPH-1:0] PH_REST = 4'b0011;

    typedef logic [2:0] edge_idx_t;

    typedef struct packed {
        logic       rise;   // new level of the affected phase
        logic [1:0] idx;    // which phase moves
    } phase_step_t;

    // Even steps raise phase (e/2 + 2) mod 4, odd steps drop phase e/2
    function automatic phase_step_t step_of(edge_idx_t e);
        phase_step_t s;
        s.rise = ~e[0];
        s.idx  = e[0] ? e[2:1] : e[2:1] + 2'd2;
        return s;
    endfunction

endpackage

// File: rtl/ccd_sweep_edge_timer.sv
module ccd_sweep_edge_timer #(
    parameter int LINE_CLKS      = 2640,
    parameter int EDGE_OFFSET    = 16,
    parameter int EDGE_SPACING   = 20,
    parameter int EDGES_PER_LINE = 132
) (
    input  logic clk,
    input  logic rst,
    input  logic hd,
    input  logic enable,
    output logic tick
);
    localparam int POS_MAX = EDGE_OFFSET + EDGE_SPACING * EDGES_PER_LINE;
    localparam int CNT_MAX = (POS_MAX > LINE_CLKS) ? POS_MAX : LINE_CLKS;
    localparam int W       = $clog2(CNT_MAX + 1);
    localparam int EW      = $clog2(EDGES_PER_LINE + 1);

    logic [W-1:0]  pix_q;
    logic [W-1:0]  pos_q;
    logic [EW-1:0] n_q;

    assign tick = enable && !hd && (n_q < EW'(EDGES_PER_LINE)) && (pix_q == pos_q);

    always_ff @(posedge clk) begin
        if (rst || hd) begin
            pix_q <= '0;
            pos_q <= W'(EDGE_OFFSET);
            n_q   <= '0;
        end else begin
            if (pix_q != W'(CNT_MAX))
                pix_q <= pix_q + 1'b1;
            if (tick) begin
                pos_q <= pos_q + W'(EDGE_SPACING);
                n_q   <= n_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ccd_sweep_phase_gen.sv
module ccd_sweep_phase_gen
    import ccd_sweep_pkg::*;
#(
    parameter int STAGES      = 2112,
    parameter int MIN_OVERLAP = 28
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           tick,
    output logic [NPH-1:0] vphase,
    output logic           last_edge
);
    localparam int SW = $clog2(STAGES + 1);
    localparam int OW = $clog2(MIN_OVERLAP + 1);

    edge_idx_t   e_q;
    logic [SW-1:0] stage_q;
    phase_step_t step;

    assign step      = step_of(e_q);
    assign last_edge = tick && (e_q[1:0] == 2'd3) && (stage_q == SW'(STAGES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            vphase  <= PH_REST;
            e_q     <= '0;
            stage_q <= '0;
        end else begin
            if (tick) begin
                vphase[step.idx] <= step.rise;
                e_q              <= e_q + 1'b1;
            end
            if (clr)
                stage_q <= '0;
            else if (tick && e_q[1:0] == 2'd3)
                stage_q <= stage_q + 1'b1;
        end
    end

    // Saturating high-time counters used by the overlap check
    logic [OW-1:0] hi_cnt [NPH];

    always_ff @(posedge clk) begin
        for (int k = 0; k < NPH; k++) begin
            if (rst || !vphase[k])
                hi_cnt[k] <= '0;
            else if (hi_cnt[k] != OW'(MIN_OVERLAP))
                hi_cnt[k] <= hi_cnt[k] + 1'b1;
        end
    end

    generate
        for (genvar k = 0; k < NPH; k++) begin : g_ovl
            localparam int SUCC = (k + 1) % NPH;
            AST_PHASE_OVERLAP: assert property (@(posedge clk) disable iff (rst)
                $fell(vphase[k]) |-> (hi_cnt[SUCC] >= OW'(MIN_OVERLAP))); // R9
        end
    endgenerate

    AST_SINGLE_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        $countones(vphase ^ $past(vphase)) <= 1); // R7

endmodule

// File: rtl/ccd_sweep_expose_gate.sv
module ccd_sweep_expose_gate #(
    parameter int SETTLE_CLKS = 180000
) (
    input  logic clk,
    input  logic rst,
    input  logic drain_hi,
    input  logic accept,
    output logic expose_ok
);
    localparam int CW = $clog2(SETTLE_CLKS + 1);

    logic [CW-1:0] cnt_q, cnt_n;
    logic          lock_q, lock_n;

    always_comb begin
        if (!drain_hi)
            cnt_n = '0;
        else if (cnt_q == CW'(SETTLE_CLKS))
            cnt_n = cnt_q;
        else
            cnt_n = cnt_q + 1'b1;
        lock_n = drain_hi && (lock_q || accept);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            lock_q    <= 1'b0;
            expose_ok <= 1'b0;
        end else begin
            cnt_q     <= cnt_n;
            lock_q    <= lock_n;
            expose_ok <= drain_hi && !lock_n && (cnt_n == CW'(SETTLE_CLKS));
        end
    end

    AST_OK_NEEDS_DRAIN: assert property (@(posedge clk) disable iff (rst)
        !drain_hi |=> !expose_ok); // R2

endmodule

// File: rtl/ccd_sweep_seq.sv
module ccd_sweep_seq
    import ccd_sweep_pkg::*;
#(
    parameter int STAGES         = 2112,
    parameter int LINE_CLKS      = 2640,
    parameter int EDGE_OFFSET    = 16,
    parameter int EDGE_SPACING   = 20,
    parameter int EDGES_PER_LINE = 132,
    parameter int FIRST_LINE     = 2,
    parameter int LAST_LINE      = 66,
    parameter int SETTLE_CLKS    = 180000,
    parameter int MIN_OVERLAP    = 28
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_req,
    input  logic       hd,
    input  logic       drain_hi,
    input  logic       expose_busy,
    output logic [3:0] vphase,
    output logic       sweeping,
    output logic       sweep_done,
    output logic       expose_ok,
    output logic       start_err
);
    localparam int LW = $clog2(LAST_LINE + 1);

    logic          running_q;
    logic          pend_q;
    logic [LW-1:0] line_q;
    logic          accept;
    logic          tick;
    logic          finish;

    assign accept   = (start_req || pend_q) && !expose_busy && !running_q;
    assign sweeping = running_q && (line_q >= LW'(FIRST_LINE)) && (line_q <= LW'(LAST_LINE));

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q  <= 1'b0;
            pend_q     <= 1'b0;
            line_q     <= '0;
            sweep_done <= 1'b0;
            start_err  <= 1'b0;
        end else begin
            sweep_done <= finish;
            start_err  <= start_err | (start_req && running_q);
            pend_q     <= !running_q && (start_req || pend_q) && expose_busy;
            if (accept) begin
                running_q <= 1'b1;
                line_q    <= '0;
            end else if (running_q) begin
                if (finish)
                    running_q <= 1'b0;
                else if (hd) begin
                    if (line_q == LW'(LAST_LINE))
                        running_q <= 1'b0;
                    else
                        line_q <= line_q + 1'b1;
                end
            end
        end
    end

    ccd_sweep_edge_timer #(
        .LINE_CLKS      (LINE_CLKS),
        .EDGE_OFFSET    (EDGE_OFFSET),
        .EDGE_SPACING   (EDGE_SPACING),
        .EDGES_PER_LINE (EDGES_PER_LINE)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .hd     (hd),
        .enable (sweeping),
        .tick   (tick)
    );

    ccd_sweep_phase_gen #(
        .STAGES      (STAGES),
        .MIN_OVERLAP (MIN_OVERLAP)
    ) u_phase (
        .clk       (clk),
        .rst       (rst),
        .clr       (accept),
        .tick      (tick),
        .vphase    (vphase),
        .last_edge (finish)
    );

    ccd_sweep_expose_gate #(
        .SETTLE_CLKS (SETTLE_CLKS)
    ) u_gate (
        .clk       (clk),
        .rst       (rst),
        .drain_hi  (drain_hi),
        .accept    (accept),
        .expose_ok (expose_ok)
    );

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sweep_done |=> !sweep_done); // R8

    AST_NO_EXPOSE_IN_SWEEP: assert property (@(posedge clk) disable iff (rst)
        running_q |-> !expose_ok); // R4

    AST_STILL_OUTSIDE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !sweeping |=> $stable(vphase)); // R5

    AST_ERR_ON_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (start_req && running_q) |=> start_err); // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        start_err |=> start_err); // R10

endmodule

// File: tb/ccd_sweep_seq_test.sv
module ccd_sweep_seq_test;

    localparam int STAGES  = 6;
    localparam int LCLK    = 40;
    localparam int OFS     = 2;
    localparam int SPC     = 4;
    localparam int EPL     = 8;
    localparam int FIRST   = 2;
    localparam int LAST    = 4;
    localparam int SETTLE  = 10;
    localparam int OVL     = 6;

    // Settle-timer vectors: {cycles drain held high, expected expose_ok}
    localparam int SETTLE_VEC [4][2] = '{'{9, 0}, '{10, 1}, '{1, 0}, '{30, 1}};
    // Phase state after each edge of the eight-edge rotation (R7)
    localparam logic [3:0] SEQ [8] = '{4'b0111, 4'b0110, 4'b1110, 4'b1100,
                                       4'b1101, 4'b1001, 4'b1011, 4'b0011};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_req = 1'b0;
    logic       hd = 1'b0;
    logic       drain_hi = 1'b0;
    logic       expose_busy = 1'b0;
    logic [3:0] vphase;
    logic       sweeping, sweep_done, expose_ok, start_err;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int kcnt = 0;
    int lnum = 0;
    bit armed = 1'b0;
    int edges = 0;
    int dones = 0;
    logic [3:0] prev_ph = 4'b0011;

    ccd_sweep_seq #(
        .STAGES(STAGES), .LINE_CLKS(LCLK), .EDGE_OFFSET(OFS), .EDGE_SPACING(SPC),
        .EDGES_PER_LINE(EPL), .FIRST_LINE(FIRST), .LAST_LINE(LAST),
        .SETTLE_CLKS(SETTLE), .MIN_OVERLAP(OVL)
    ) uut (
        .clk(clk), .rst(rst), .start_req(start_req), .hd(hd), .drain_hi(drain_hi),
        .expose_busy(expose_busy), .vphase(vphase), .sweeping(sweeping),
        .sweep_done(sweep_done), .expose_ok(expose_ok), .start_err(start_err)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit good, input string req, input int act, input int exp);
        compared++;
        if (!good) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        kcnt <= hd ? 0 : kcnt + 1;
        if (cyc > 20000) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // Edge monitor: location, order and done timing of every phase change
    always @(negedge clk) begin
        if (!rst) begin
            if (vphase != prev_ph) begin
                chk(armed && lnum >= FIRST && lnum <= LAST, "R5 edge line", lnum, FIRST);
                chk(((kcnt - OFS - 1) % SPC) == 0 && kcnt > OFS, "R6 edge position", kcnt, OFS + 1);
                chk(vphase == SEQ[edges % 8], "R7 phase order", vphase, SEQ[edges % 8]);
                edges++;
            end
            if (sweep_done) begin
                dones++;
                chk(lnum == 4 && kcnt == OFS + 1 + (EPL - 1) * SPC, "R8 done timing",
                    kcnt, OFS + 1 + (EPL - 1) * SPC);
            end
            prev_ph = vphase;
        end
    end

    task automatic run_line(input bit poke);
        hd = 1'b1;
        lnum++;
        @(negedge clk);
        hd = 1'b0;
        for (int c = 1; c < LCLK; c++) begin
            if (poke && c == 10) start_req = 1'b1;
            else start_req = 1'b0;
            @(negedge clk);
        end
        start_req = 1'b0;
    endtask

    task automatic settle(input int n);
        drain_hi = 1'b0;
        repeat (2) @(negedge clk);
        drain_hi = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(vphase == 4'b0011, "R1 vphase", vphase, 3);
        chk(!sweeping && !sweep_done && !expose_ok && !start_err, "R1 flags",
            {sweeping, sweep_done, expose_ok, start_err}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(vphase == 4'b0011 && !expose_ok, "R1 after release", vphase, 3);

        // R2: settle timer vectors
        for (int i = 0; i < 4; i++) begin
            settle(SETTLE_VEC[i][0]);
            chk(expose_ok == SETTLE_VEC[i][1][0], "R2 settle", expose_ok, SETTLE_VEC[i][1]);
        end
        drain_hi = 1'b0;
        @(negedge clk);
        chk(!expose_ok, "R2 drain low", expose_ok, 0);

        // R3: request deferred behind running exposure
        settle(SETTLE);
        expose_busy = 1'b1;
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        for (int l = 0; l < 4; l++) run_line(1'b0);
        chk(vphase == 4'b0011 && edges == 0, "R3 no motion while busy", edges, 0);
        chk(!sweeping, "R3 not sweeping", sweeping, 0);
        chk(expose_ok, "R3 grant kept while pending", expose_ok, 1);
        expose_busy = 1'b0;
        armed = 1'b1;
        lnum = 0;
        @(negedge clk);
        // R4: acceptance withdraws the grant
        chk(!expose_ok, "R4 grant withdrawn", expose_ok, 1'b0);
        run_line(1'b0);
        chk(!sweeping, "R5 line 1 outside window", sweeping, 0);
        run_line(1'b0);
        chk(sweeping, "R5 line 2 inside window", sweeping, 1);
        run_line(1'b1);
        chk(start_err, "R10 start mid-sweep flagged", start_err, 1);
        run_line(1'b0);
        run_line(1'b0);
        chk(edges == STAGES * 4, "R8 stage count", edges, STAGES * 4);
        chk(dones == 1, "R8 done pulses", dones, 1);
        chk(vphase == 4'b0011 && !sweeping, "R8 stopped at rest", vphase, 3);
        chk(!expose_ok, "R4 grant stays off", expose_ok, 0);

        // R4: grant returns after drain cycles
        settle(SETTLE);
        chk(expose_ok, "R4 grant after new settle", expose_ok, 1);

        // Second sweep, immediate acceptance
        armed = 1'b0;
        start_req = 1'b1;
        armed = 1'b1;
        lnum = 0;
        @(negedge clk);
        start_req = 1'b0;
        for (int l = 0; l < 5; l++) run_line(1'b0);
        chk(edges == 2 * STAGES * 4, "R8 second sweep count", edges, 2 * STAGES * 4);
        chk(dones == 2, "R8 second done", dones, 2);
        chk(start_err, "R10 sticky", start_err, 1);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!start_err, "R10 cleared by reset", start_err, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule